// File: doc/BRIEF.md
# Two-Way Write-Back Line Cache

This block sits between a 32-bit processor's simple valid/ready memory bus and a memory controller that moves whole lines. Every processor load and store to external memory passes through it. It holds 8 KiB of data in 128 sets of two ways, with 32-byte lines. A least-recently-used bit in each set picks the way to replace. Stores are write-back: a store that hits only changes the cached copy and marks the line dirty.

Neither the line storage nor the downstream memory accepts a byte mask. A partial store therefore reads the cached word, merges the enabled bytes into it, and writes the whole line back into storage. A dirty line always goes downstream as a complete 256-bit line. On a miss, the cache first writes back a dirty victim, then refills the line, and then completes the access by looking it up again.

A flush request makes the cache walk every set and way and write back each dirty line. The processor is stalled until the flush is done.

Top module: `cwb_cache`

## Requirements
- R1: After reset every line is invalid and clean, and `cpu_ready`, `mem_req` and `flush_done` are low. The first access to any address is a miss.
- R2: A read hit returns the addressed word with `cpu_ready` high in the cycle after `cpu_valid` is first sampled. It causes no memory transaction, and `cpu_ready` is a single-cycle pulse.
- R3: A write (`cpu_wstrb` nonzero) that hits updates only the enabled bytes, where strobe bit i covers data bits [8i+7:8i]. Nothing is sent to memory at that time.
- R4: On a miss the way named by the set's LRU bit is the victim. A clean or invalid victim costs exactly one line read, and then the access completes.
- R5: A dirty victim is written out as one complete line to its own line address before the refill read. Word i of a line is carried on bits [32i+31:32i].
- R6: After every hit or refill, the set's LRU bit names the way that was not just used.
- R7: A flush writes back every dirty line exactly once and keeps `cpu_ready` low throughout. It ends with a single-cycle `flush_done` pulse. Afterwards the lines stay valid and clean, so a second flush writes nothing.
- R8: `mem_req` stays high, with `mem_we`, `mem_line_addr` and `mem_wdata` held stable, until `mem_ack`. Each acknowledge completes exactly one transaction.
- R9: Address bits [31:12] form the tag, bits [11:5] the set index and bits [4:2] the word within the line. `mem_line_addr` is the byte address bits [31:5] of the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor access request, held until ready |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_wstrb | input | 4 | Byte enables; zero means read |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | Access complete (one-cycle pulse) |
| flush_req | input | 1 | Write back all dirty lines, held until flush_done |
| flush_done | output | 1 | Flush complete (one-cycle pulse) |
| mem_req | output | 1 | Memory line transaction request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_line_addr | output | 27 | Line address (byte address bits [31:5]) |
| mem_wdata | output | 256 | Line data to memory |
| mem_rdata | input | 256 | Line data from memory, valid with mem_ack |
| mem_ack | input | 1 | Transaction complete |

## Verification
Some properties are checked on every cycle:
- at most one way ever matches a lookup;
- a line write is only requested for an entry that is valid and dirty;
- a refill never lands on a dirty line;
- the memory request holds its fields until acknowledged;
- `cpu_ready` is a pulse;
- after each hit the set's LRU bit turns away from the way that was used.

Other behaviour only the bench's scenarios can show. Byte merging, and the data a load returns after a chain of evictions, are compared against a flat reference memory. The order of write-back and refill is checked by transaction sequence. The exact number of lines a flush writes is checked with a known set of dirty lines. Finally, memory is compared word by word with the reference after a flush.

// File: rtl/cwb_pkg.sv
package cwb_pkg;

  localparam int WORD_W  = 32;
  localparam int STRB_W  = WORD_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESP,
    ST_WB,
    ST_FILL,
    ST_FL_SCAN,
    ST_FL_WB,
    ST_FL_DONE
  } cwb_state_e;

  // Byte-lane merge: enabled lanes take the new data, the rest keep the old word.
  function automatic logic [WORD_W-1:0] merge_bytes(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] new_w,
    input logic [STRB_W-1:0] strb
  );
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int b = 0; b < STRB_W; b++) begin
      if (strb[b]) r[8*b +: 8] = new_w[8*b +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/cwb_tag_store.sv
module cwb_tag_store #(
  parameter int NUM_SETS = 128,
  parameter int TAG_W    = 20,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      idx,
  output logic [1:0][TAG_W-1:0] rd_tag,
  output logic [1:0]            rd_valid,
  output logic [1:0]            rd_dirty,
  output logic                  rd_lru,
  input  logic                  wr_en,
  input  logic                  wr_way,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic                  wr_dirty,
  input  logic                  lru_we,
  input  logic                  lru_val
);

  logic [NUM_SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0]    tags [NUM_SETS];
    logic [NUM_SETS-1:0] vld_q;
    logic [NUM_SETS-1:0] drt_q;
    logic                sel;

    assign sel = wr_en && (wr_way == 1'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        drt_q <= '0;
      end else if (sel) begin
        vld_q[idx] <= 1'b1;
        drt_q[idx] <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) tags[idx] <= wr_tag;
    end

    assign rd_tag[w]   = tags[idx];
    assign rd_valid[w] = vld_q[idx];
    assign rd_dirty[w] = drt_q[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lru_q      <= '0;
    else if (lru_we) lru_q[idx] <= lru_val;
  end

  assign rd_lru = lru_q[idx];

endmodule

// File: rtl/cwb_data_store.sv
module cwb_data_store #(
  parameter int NUM_SETS = 128,
  parameter int LINE_W   = 256,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input  logic                   clk,
  input  logic [IDX_W-1:0]       idx,
  output logic [1:0][LINE_W-1:0] rd_line,
  input  logic                   wr_en,
  input  logic                   wr_way,
  input  logic [LINE_W-1:0]      wr_line
);

  // Whole-line write only: the array has no per-byte enables.
  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [LINE_W-1:0] lines [NUM_SETS];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == 1'(w))) lines[idx] <= wr_line;
    end

    assign rd_line[w] = lines[idx];
  end

endmodule

// File: rtl/cwb_ctrl.sv
module cwb_ctrl
  import cwb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_SETS   = 128,
  parameter int LINE_WORDS = 8,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(NUM_SETS),
  localparam int BOFF_W    = OFF_W + 2,
  localparam int TAG_W     = ADDR_W - IDX_W - BOFF_W,
  localparam int LINE_W    = LINE_WORDS * WORD_W,
  localparam int LADDR_W   = ADDR_W - BOFF_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_valid,
  input  logic [ADDR_W-1:0]      cpu_addr,
  input  logic [WORD_W-1:0]      cpu_wdata,
  input  logic [STRB_W-1:0]      cpu_wstrb,
  output logic [WORD_W-1:0]      cpu_rdata,
  output logic                   cpu_ready,
  input  logic                   flush_req,
  output logic                   flush_done,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [LADDR_W-1:0]     mem_line_addr,
  output logic [LINE_W-1:0]      mem_wdata,
  input  logic [LINE_W-1:0]      mem_rdata,
  input  logic                   mem_ack,
  output logic [IDX_W-1:0]       st_idx,
  input  logic [1:0][TAG_W-1:0]  ts_tag,
  input  logic [1:0]             ts_valid,
  input  logic [1:0]             ts_dirty,
  input  logic                   ts_lru,
  output logic                   ts_we,
  output logic                   ts_way,
  output logic [TAG_W-1:0]       ts_wtag,
  output logic                   ts_wdirty,
  output logic                   ts_lru_we,
  output logic                   ts_lru_val,
  input  logic [1:0][LINE_W-1:0] ds_line,
  output logic                   ds_we,
  output logic                   ds_way,
  output logic [LINE_W-1:0]      ds_wline
);

  function automatic logic [WORD_W-1:0] line_get(
    input logic [LINE_W-1:0] l, input logic [OFF_W-1:0] o);
    return l[WORD_W*o +: WORD_W];
  endfunction

  function automatic logic [LINE_W-1:0] line_put(
    input logic [LINE_W-1:0] l, input logic [OFF_W-1:0] o, input logic [WORD_W-1:0] w);
    logic [LINE_W-1:0] r;
    r = l;
    r[WORD_W*o +: WORD_W] = w;
    return r;
  endfunction

  cwb_state_e        state_q, state_d;
  logic              victim_q, victim_d;
  logic [IDX_W-1:0]  fl_idx_q, fl_idx_d;
  logic              fl_way_q, fl_way_d;
  logic [WORD_W-1:0] rdata_q;

  logic [TAG_W-1:0]  tag_c;
  logic [IDX_W-1:0]  idx_c;
  logic [OFF_W-1:0]  off_c;
  logic              unused_lo;

  assign tag_c     = cpu_addr[ADDR_W-1 -: TAG_W];
  assign idx_c     = cpu_addr[BOFF_W +: IDX_W];
  assign off_c     = cpu_addr[2 +: OFF_W];
  assign unused_lo = ^cpu_addr[1:0];

  // Named internal events
  logic              fl_active, fl_last;
  logic [1:0]        hit_vec;
  logic              any_hit, hit_way, hit_evt, miss_evt, fill_evt, wb_done;
  logic              sel_way, sel_valid, sel_dirty;
  logic [TAG_W-1:0]  sel_tag;
  logic [LINE_W-1:0] sel_line, hit_line;
  logic              is_write;

  assign fl_active = (state_q == ST_FL_SCAN) || (state_q == ST_FL_WB);
  assign fl_last   = (fl_idx_q == IDX_W'(NUM_SETS - 1)) && fl_way_q;
  assign st_idx    = fl_active ? fl_idx_q : idx_c;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hit_vec[w] = ts_valid[w] && (ts_tag[w] == tag_c);
  end

  assign any_hit  = |hit_vec;
  assign hit_way  = hit_vec[1];
  assign is_write = |cpu_wstrb;
  assign hit_evt  = (state_q == ST_IDLE) && cpu_valid && any_hit;
  assign miss_evt = (state_q == ST_IDLE) && cpu_valid && !any_hit;
  assign fill_evt = (state_q == ST_FILL) && mem_ack;
  assign wb_done  = ((state_q == ST_WB) || (state_q == ST_FL_WB)) && mem_ack;

  assign sel_way   = (state_q == ST_IDLE) ? ts_lru : (fl_active ? fl_way_q : victim_q);
  assign sel_valid = ts_valid[sel_way];
  assign sel_dirty = ts_dirty[sel_way];
  assign sel_tag   = ts_tag[sel_way];
  assign sel_line  = ds_line[sel_way];
  assign hit_line  = ds_line[hit_way];

  always_comb begin
    state_d  = state_q;
    victim_d = victim_q;
    fl_idx_d = fl_idx_q;
    fl_way_d = fl_way_q;
    case (state_q)
      ST_IDLE: begin
        if (cpu_valid) begin
          if (any_hit) begin
            state_d = ST_RESP;
          end else begin
            victim_d = ts_lru;
            state_d  = (sel_valid && sel_dirty) ? ST_WB : ST_FILL;
          end
        end else if (flush_req) begin
          state_d  = ST_FL_SCAN;
          fl_idx_d = '0;
          fl_way_d = 1'b0;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      ST_WB:   if (mem_ack) state_d = ST_FILL;
      ST_FILL: if (mem_ack) state_d = ST_IDLE;
      ST_FL_SCAN, ST_FL_WB: begin
        if (state_q == ST_FL_WB && !mem_ack) begin
          state_d = ST_FL_WB;
        end else if (state_q == ST_FL_SCAN && sel_valid && sel_dirty) begin
          state_d = ST_FL_WB;
        end else if (fl_last) begin
          state_d = ST_FL_DONE;
        end else begin
          state_d = ST_FL_SCAN;
          {fl_idx_d, fl_way_d} = {fl_idx_q, fl_way_q} + (IDX_W + 1)'(1);
        end
      end
      ST_FL_DONE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      victim_q <= 1'b0;
      fl_idx_q <= '0;
      fl_way_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      state_q  <= state_d;
      victim_q <= victim_d;
      fl_idx_q <= fl_idx_d;
      fl_way_q <= fl_way_d;
      if (hit_evt) rdata_q <= line_get(hit_line, off_c);
    end
  end

  // Tag/valid/dirty updates: store hit marks dirty, fill and write-back leave clean.
  assign ts_we      = (hit_evt && is_write) || fill_evt || wb_done;
  assign ts_way     = fill_evt ? victim_q : (wb_done ? sel_way : hit_way);
  assign ts_wtag    = wb_done ? sel_tag : tag_c;
  assign ts_wdirty  = !(fill_evt || wb_done);
  assign ts_lru_we  = hit_evt || fill_evt;
  assign ts_lru_val = fill_evt ? !victim_q : !hit_way;

  // Data: read-merge-write of the whole line on a store hit, full line on fill.
  assign ds_we    = (hit_evt && is_write) || fill_evt;
  assign ds_way   = fill_evt ? victim_q : hit_way;
  assign ds_wline = fill_evt ? mem_rdata
                  : line_put(hit_line, off_c,
                             merge_bytes(line_get(hit_line, off_c), cpu_wdata, cpu_wstrb));

  assign cpu_ready     = (state_q == ST_RESP);
  assign cpu_rdata     = rdata_q;
  assign flush_done    = (state_q == ST_FL_DONE);
  assign mem_req       = (state_q == ST_WB) || (state_q == ST_FILL) || (state_q == ST_FL_WB);
  assign mem_we        = (state_q == ST_WB) || (state_q == ST_FL_WB);
  assign mem_line_addr = mem_we ? {sel_tag, st_idx} : {tag_c, idx_c};
  assign mem_wdata     = sel_line;

  // Assertions
  AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R9

  AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (sel_valid && sel_dirty)); // R5

  AST_FILL_NOT_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |-> !(sel_valid && sel_dirty)); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_line_addr))); // R8

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready); // R2

  AST_LRU_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (ts_lru != $past(hit_way))); // R6

  AST_FLUSH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_active && !miss_evt) |-> !cpu_ready); // R7

endmodule

// File: rtl/cwb_cache.sv
module cwb_cache
  import cwb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_SETS   = 128,
  parameter int LINE_WORDS = 8,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(NUM_SETS),
  localparam int BOFF_W    = OFF_W + 2,
  localparam int TAG_W     = ADDR_W - IDX_W - BOFF_W,
  localparam int LINE_W    = LINE_WORDS * WORD_W,
  localparam int LADDR_W   = ADDR_W - BOFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_valid,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [WORD_W-1:0]  cpu_wdata,
  input  logic [STRB_W-1:0]  cpu_wstrb,
  output logic [WORD_W-1:0]  cpu_rdata,
  output logic               cpu_ready,
  input  logic               flush_req,
  output logic               flush_done,
  output logic               mem_req,
  output logic               mem_we,
  output logic [LADDR_W-1:0] mem_line_addr,
  output logic [LINE_W-1:0]  mem_wdata,
  input  logic [LINE_W-1:0]  mem_rdata,
  input  logic               mem_ack
);

  logic [IDX_W-1:0]        st_idx;
  logic [1:0][TAG_W-1:0]   ts_tag;
  logic [1:0]              ts_valid, ts_dirty;
  logic                    ts_lru, ts_we, ts_way, ts_wdirty, ts_lru_we, ts_lru_val;
  logic [TAG_W-1:0]        ts_wtag;
  logic [1:0][LINE_W-1:0]  ds_line;
  logic                    ds_we, ds_way;
  logic [LINE_W-1:0]       ds_wline;

  cwb_ctrl #(
    .ADDR_W(ADDR_W), .NUM_SETS(NUM_SETS), .LINE_WORDS(LINE_WORDS)
  ) u_ctrl (
    .clk, .rst_n,
    .cpu_valid, .cpu_addr, .cpu_wdata, .cpu_wstrb, .cpu_rdata, .cpu_ready,
    .flush_req, .flush_done,
    .mem_req, .mem_we, .mem_line_addr, .mem_wdata, .mem_rdata, .mem_ack,
    .st_idx, .ts_tag, .ts_valid, .ts_dirty, .ts_lru,
    .ts_we, .ts_way, .ts_wtag, .ts_wdirty, .ts_lru_we, .ts_lru_val,
    .ds_line, .ds_we, .ds_way, .ds_wline
  );

  cwb_tag_store #(.NUM_SETS(NUM_SETS), .TAG_W(TAG_W)) u_tags (
    .clk, .rst_n, .idx(st_idx),
    .rd_tag(ts_tag), .rd_valid(ts_valid), .rd_dirty(ts_dirty), .rd_lru(ts_lru),
    .wr_en(ts_we), .wr_way(ts_way), .wr_tag(ts_wtag), .wr_dirty(ts_wdirty),
    .lru_we(ts_lru_we), .lru_val(ts_lru_val)
  );

  cwb_data_store #(.NUM_SETS(NUM_SETS), .LINE_W(LINE_W)) u_data (
    .clk, .idx(st_idx), .rd_line(ds_line),
    .wr_en(ds_we), .wr_way(ds_way), .wr_line(ds_wline)
  );

endmodule

// File: tb/cwb_cache_tb.sv
module cwb_cache_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_valid = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [3:0]   cpu_wstrb = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_ready;
  logic         flush_req = 1'b0;
  logic         flush_done;
  logic         mem_req, mem_we;
  logic [26:0]  mem_line_addr;
  logic [255:0] mem_wdata;
  logic [255:0] mem_rdata = '0;
  logic         mem_ack = 1'b0;

  always #5 clk = ~clk;

  cwb_cache u_dut (
    .clk, .rst_n, .cpu_valid, .cpu_addr, .cpu_wdata, .cpu_wstrb, .cpu_rdata,
    .cpu_ready, .flush_req, .flush_done, .mem_req, .mem_we, .mem_line_addr,
    .mem_wdata, .mem_rdata, .mem_ack
  );

  int tests = 0, fails = 0;
  logic [255:0] bmem [512];
  logic [31:0]  ref_mem [4096];
  int rd_cnt = 0, wr_cnt = 0, seq = 0, rd_seq = 0, wr_seq = 0, hs_err = 0;
  logic [26:0]  last_rd_addr, last_wr_addr;
  logic [255:0] last_wr_data;

  function automatic logic [31:0] init_word(int w);
    return (32'(w) * 32'h9E37_79B9) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] addr_of(int t, int i, int w);
    return (32'(t) << 12) | (32'(i) << 5) | (32'(w) << 2);
  endfunction

  function automatic logic [31:0] exp_merge(logic [31:0] o, logic [31:0] n, logic [3:0] s);
    logic [31:0] m;
    m = {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    return (o & ~m) | (n & m);
  endfunction

  function automatic logic [255:0] ref_line(int ln);
    logic [255:0] l;
    for (int j = 0; j < 8; j++) l[32*j +: 32] = ref_mem[ln*8 + j];
    return l;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Memory responder: acknowledges each request on the third sampled cycle.
  initial begin
    int cnt;
    bit pend;
    logic [26:0]  h_addr;
    logic         h_we;
    logic [255:0] h_wd;
    cnt = 0;
    pend = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        cnt = 0;
        pend = 0;
      end else if (mem_req) begin
        if (pend && (h_addr != mem_line_addr || h_we != mem_we || (mem_we && h_wd != mem_wdata)))
          hs_err++;
        h_addr = mem_line_addr;
        h_we = mem_we;
        h_wd = mem_wdata;
        pend = 1;
        cnt++;
        if (cnt == 3) begin
          seq++;
          if (mem_we) begin
            bmem[mem_line_addr[8:0]] = mem_wdata;
            wr_cnt++;
            wr_seq = seq;
            last_wr_addr = mem_line_addr;
            last_wr_data = mem_wdata;
          end else begin
            mem_rdata = bmem[mem_line_addr[8:0]];
            rd_cnt++;
            rd_seq = seq;
            last_rd_addr = mem_line_addr;
          end
          mem_ack = 1'b1;
        end
      end
    end
  end

  task automatic cpu_op(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                        output logic [31:0] q, output int lat);
    @(negedge clk);
    cpu_addr = a;
    cpu_wdata = d;
    cpu_wstrb = s;
    cpu_valid = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!cpu_ready);
    q = cpu_rdata;
    cpu_valid = 1'b0;
    cpu_wstrb = '0;
    if (s != 0) ref_mem[a[13:2]] = exp_merge(ref_mem[a[13:2]], d, s);
  endtask

  task automatic do_flush(output int ready_seen, output int wrote);
    int w0;
    w0 = wr_cnt;
    ready_seen = 0;
    @(negedge clk);
    flush_req = 1'b1;
    do begin
      @(negedge clk);
      if (cpu_ready) ready_seen++;
    end while (!flush_done);
    flush_req = 1'b0;
    @(negedge clk);
    chk(!flush_done, "R7 flush_done pulse", 256'(flush_done), 256'd0);
    wrote = wr_cnt - w0;
  endtask

  task automatic mem_compare(input string what);
    int bad;
    bad = 0;
    for (int i = 0; i < 512; i++)
      if (bmem[i] != ref_line(i)) bad++;
    chk(bad == 0, what, 256'(bad), 256'd0);
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog R1..all actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] q, a;
    int lat, r0, w0, rs, wn;
    logic [31:0] A, B, C, D, E;

    for (int i = 0; i < 512; i++)
      for (int j = 0; j < 8; j++) begin
        bmem[i][32*j +: 32] = init_word(i*8 + j);
        ref_mem[i*8 + j] = init_word(i*8 + j);
      end
    void'($urandom(32'd7321));

    repeat (3) @(negedge clk);
    chk(!cpu_ready && !mem_req && !flush_done, "R1 outputs during reset",
        256'({cpu_ready, mem_req, flush_done}), 256'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_ready && !mem_req && !flush_done, "R1 outputs after reset",
        256'({cpu_ready, mem_req, flush_done}), 256'd0);

    A = addr_of(0, 2, 0);
    B = addr_of(1, 2, 0);
    C = addr_of(2, 2, 0);
    D = addr_of(3, 2, 0);
    E = addr_of(0, 8, 5);

    // First access misses with one line read (R1, R4, R9)
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_op(A, 0, 4'h0, q, lat);
    chk(rd_cnt - r0 == 1 && wr_cnt == w0, "R4 cold miss traffic", 256'(rd_cnt - r0), 256'd1);
    chk(lat >= 4, "R1 first access misses", 256'(lat), 256'd4);
    chk(last_rd_addr == A[31:5], "R9 refill line address", 256'(last_rd_addr), 256'(A[31:5]));
    chk(q == ref_mem[A[13:2]], "R4 miss read data", 256'(q), 256'(ref_mem[A[13:2]]));

    // Read hit (R2)
    r0 = rd_cnt;
    cpu_op(A, 0, 4'h0, q, lat);
    chk(lat == 1, "R2 hit latency", 256'(lat), 256'd1);
    chk(rd_cnt == r0 && wr_cnt == w0, "R2 hit no traffic", 256'(rd_cnt - r0), 256'd0);
    @(negedge clk);
    chk(!cpu_ready, "R2 ready is a pulse", 256'(cpu_ready), 256'd0);

    // Partial store hit (R3)
    cpu_op(A + 4, 32'hDEAD_BEEF, 4'b0101, q, lat);
    chk(lat == 1 && rd_cnt == r0 && wr_cnt == w0, "R3 store hit no traffic", 256'(wr_cnt - w0), 256'd0);
    cpu_op(A + 4, 0, 4'h0, q, lat);
    chk(q == ref_mem[A[13:2] + 1], "R3 merged bytes", 256'(q), 256'(ref_mem[A[13:2] + 1]));
    cpu_op(A + 4, 32'h1234_5678, 4'b1000, q, lat);
    cpu_op(A + 4, 0, 4'h0, q, lat);
    chk(q == ref_mem[A[13:2] + 1], "R3 single top byte", 256'(q), 256'(ref_mem[A[13:2] + 1]));

    // LRU ordering (R4, R6): A in way0, B fills way1, A hit, C evicts B
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_op(B, 0, 4'h0, q, lat);
    chk(q == ref_mem[B[13:2]], "R4 second-way fill data", 256'(q), 256'(ref_mem[B[13:2]]));
    cpu_op(A, 0, 4'h0, q, lat);
    chk(lat == 1, "R6 both ways resident", 256'(lat), 256'd1);
    cpu_op(C, 0, 4'h0, q, lat);
    chk(wr_cnt == w0, "R4 clean victim not written", 256'(wr_cnt - w0), 256'd0);
    cpu_op(A, 0, 4'h0, q, lat);
    chk(lat == 1, "R6 recently used line kept", 256'(lat), 256'd1);
    r0 = rd_cnt;
    cpu_op(B, 0, 4'h0, q, lat);
    chk(rd_cnt - r0 == 1 && wr_cnt == w0, "R6 LRU line was evicted", 256'(rd_cnt - r0), 256'd1);

    // Dirty eviction of A (R5)
    r0 = rd_cnt;
    cpu_op(D, 0, 4'h0, q, lat);
    chk(wr_cnt - w0 == 1 && rd_cnt - r0 == 1, "R5 dirty victim traffic", 256'(wr_cnt - w0), 256'd1);
    chk(wr_seq < rd_seq, "R5 write-back before refill", 256'(wr_seq), 256'(rd_seq));
    chk(last_wr_addr == A[31:5], "R5 write-back address", 256'(last_wr_addr), 256'(A[31:5]));
    chk(last_wr_data == ref_line(int'(A[13:5])), "R5 full line data", last_wr_data, ref_line(int'(A[13:5])));
    chk(q == ref_mem[D[13:2]], "R5 read after eviction", 256'(q), 256'(ref_mem[D[13:2]]));

    // Flush with two known dirty lines (R7)
    cpu_op(D + 8, 32'hCAFE_F00D, 4'b1111, q, lat);
    cpu_op(E, 32'h0BAD_0BAD, 4'b0011, q, lat);
    do_flush(rs, wn);
    chk(rs == 0, "R7 cpu stalled during flush", 256'(rs), 256'd0);
    chk(wn == 2, "R7 dirty lines written", 256'(wn), 256'd2);
    mem_compare("R7 memory after flush");
    do_flush(rs, wn);
    chk(wn == 0, "R7 second flush writes nothing", 256'(wn), 256'd0);
    r0 = rd_cnt;
    cpu_op(D + 8, 0, 4'h0, q, lat);
    chk(lat == 1 && rd_cnt == r0, "R7 lines remain valid", 256'(lat), 256'd1);
    chk(q == ref_mem[D[13:2] + 2], "R7 data after flush", 256'(q), 256'(ref_mem[D[13:2] + 2]));

    // Constrained random traffic (R2, R3, R4, R5, R6)
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] s;
      logic [31:0] d;
      a = addr_of(int'($urandom_range(0, 3)), int'($urandom_range(0, 7)) * 3, int'($urandom_range(0, 7)));
      d = $urandom;
      s = ($urandom_range(0, 1) == 1) ? 4'($urandom_range(1, 15)) : 4'h0;
      cpu_op(a, d, s, q, lat);
      if (s == 0)
        chk(q == ref_mem[a[13:2]], "R3 R4 R5 random read data", 256'(q), 256'(ref_mem[a[13:2]]));
    end
    do_flush(rs, wn);
    chk(rs == 0, "R7 stall in final flush", 256'(rs), 256'd0);
    mem_compare("R5 R7 memory after random traffic");
    chk(hs_err == 0, "R8 request held until ack", 256'(hs_err), 256'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule